// File: doc/BRIEF.md
# Peripheral DMA request handshake unit

This unit sits between up to sixteen peripherals and the channel engine of a DMA controller. Each peripheral drives four request lines: burst, last burst, single and last single. While the engine is idle, the unit picks one pending request. It then issues a one-cycle start to the engine. The start carries the peripheral index, whether the request is a burst, and whether the request is the last one of the transaction.

When the engine reports done, the unit returns a one-cycle clear pulse to the serviced peripheral. A terminal-count pulse goes with the clear when the transaction has finished. That is the case when the request was one of the two last kinds, or when the engine reports that its transfer counter has reached zero.

The unit also holds two sticky interrupt status bits, one for errors and one for terminal counts. Each bit has an enable and a write-one-to-clear pulse input. The unit drives a combined interrupt from the two. All logic runs on the one bus clock. Bus mastering and data movement belong to the engine.

Top module: `pdma_hs`

## Requirements
- R1: Among peripherals with an eligible request, the lowest-numbered one is started, and `start_periph_o` carries its index.
- R2: For the chosen peripheral, a burst-kind request (burst or last burst) wins over a single-kind one, so `start_burst_o`=1. `start_last_o` is 1 when the winning kind's last line is high: last burst for a burst, last single for a single.
- R3: `start_o` is a one-cycle pulse. It appears in the cycle after an eligible request is seen while idle. No further start follows until the engine has reported done.
- R4: One cycle after `done_i` is seen while busy, `clear_o` pulses for exactly one cycle, with only the serviced peripheral's bit set.
- R5: `tc_o` pulses on the serviced peripheral's bit together with the clear when the request was a last kind or `cnt_zero_i` was 1 with done. Otherwise it stays 0.
- R6: After its clear, a peripheral is not started again until all four of its request lines have been low for at least one cycle. Other peripherals are served in the meantime.
- R7: The error status bit is set by `err_i`=1 together with done while busy. It holds until an `err_clr_i` pulse. When a set and a clear occur in the same cycle, the set wins.
- R8: The terminal-count status bit is set whenever a `tc_o` pulse is issued. It holds until a `tc_clr_i` pulse.
- R9: `irq_err_o` and `irq_tc_o` are each status bit ANDed with its enable input (1 = enabled). `irq_o` is their OR.
- R10: After reset, all outputs are 0 and the unit is idle.
- R11: `done_i` while idle has no effect: no clear, no terminal count and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_req_i | input | 16 | Burst request, one bit per peripheral |
| lburst_req_i | input | 16 | Last burst request per peripheral |
| single_req_i | input | 16 | Single request per peripheral |
| lsingle_req_i | input | 16 | Last single request per peripheral |
| done_i | input | 1 | Engine has finished the started request |
| cnt_zero_i | input | 1 | Engine transfer counter reached zero (sampled with done) |
| err_i | input | 1 | Engine saw an error (sampled with done) |
| err_clr_i | input | 1 | Write-one-to-clear pulse for error status |
| tc_clr_i | input | 1 | Write-one-to-clear pulse for terminal-count status |
| err_en_i | input | 1 | Error interrupt enable |
| tc_en_i | input | 1 | Terminal-count interrupt enable |
| start_o | output | 1 | One-cycle start to the engine |
| start_periph_o | output | 4 | Index of started peripheral |
| start_burst_o | output | 1 | Started request is a burst kind |
| start_last_o | output | 1 | Started request is a last kind |
| clear_o | output | 16 | Per-peripheral request clear pulse |
| tc_o | output | 16 | Per-peripheral terminal-count pulse |
| irq_err_o | output | 1 | Enabled error interrupt |
| irq_tc_o | output | 1 | Enabled terminal-count interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- the single-cycle and one-hot shape of the start and clear pulses;
- that a terminal count never appears without the matching clear;
- that clears only follow a done accepted while busy, and no second start overlaps an open request;
- the stickiness of the error status and the OR form of the combined interrupt.

Only the directed scenarios can show the rest: which peripheral and kind wins a contest, the decoded last flag, the terminal-count decision from kind versus counter zero, the hold-off until a peripheral drops its lines, and the set-wins rule of the status bits.

// File: rtl/pdma_hs_pkg.sv
package pdma_hs_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} hs_state_e;
  typedef struct packed {
    logic burst;
    logic last;
  } req_kind_t;
endpackage

// File: rtl/pdma_hs_arb.sv
module pdma_hs_arb
  import pdma_hs_pkg::*;
#(
  parameter int N   = 16,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   burst_i,
  input  logic [N-1:0]   lburst_i,
  input  logic [N-1:0]   single_i,
  input  logic [N-1:0]   lsingle_i,
  input  logic [N-1:0]   block_i,
  output logic [N-1:0]   any_o,
  output logic           valid_o,
  output logic [IDW-1:0] idx_o,
  output req_kind_t      kind_o
);
  logic [N-1:0] elig;

  assign any_o   = burst_i | lburst_i | single_i | lsingle_i;
  assign elig    = any_o & ~block_i;
  assign valid_o = |elig;

  // scan downward so the lowest index is written last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = IDW'(i);
    end
  end

  always_comb begin
    kind_o.burst = burst_i[idx_o] | lburst_i[idx_o];
    kind_o.last  = kind_o.burst ? lburst_i[idx_o] : lsingle_i[idx_o];
  end
endmodule

// File: rtl/pdma_hs_ctrl.sv
module pdma_hs_ctrl
  import pdma_hs_pkg::*;
#(
  parameter int N   = 16,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [IDW-1:0] idx_i,
  input  req_kind_t      kind_i,
  input  logic [N-1:0]   any_i,
  input  logic           done_i,
  input  logic           cnt_zero_i,
  input  logic           err_i,
  output logic [N-1:0]   block_o,
  output logic           start_o,
  output logic [IDW-1:0] start_idx_o,
  output req_kind_t      start_kind_o,
  output logic [N-1:0]   clear_o,
  output logic [N-1:0]   tc_o,
  output logic           err_set_o,
  output logic           tc_set_o
);
  hs_state_e    state_q, state_d;
  logic [N-1:0] clr_d, tc_d, blk_d;
  logic         fin, tc_hit;

  assign fin    = (state_q == ST_BUSY) && done_i;
  assign tc_hit = start_kind_o.last | cnt_zero_i;

  always_comb begin
    state_d = state_q;
    clr_d   = '0;
    tc_d    = '0;
    unique case (state_q)
      ST_IDLE: if (valid_i) state_d = ST_BUSY;
      ST_BUSY: if (done_i) begin
        state_d            = ST_IDLE;
        clr_d[start_idx_o] = 1'b1;
        tc_d[start_idx_o]  = tc_hit;
      end
      default: state_d = ST_IDLE;
    endcase
    // hold-off ends once the peripheral drops every line
    blk_d = clr_d | (block_o & any_i);
  end

  assign err_set_o = fin & err_i;
  assign tc_set_o  = fin & tc_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      start_o      <= 1'b0;
      start_idx_o  <= '0;
      start_kind_o <= '0;
      clear_o      <= '0;
      tc_o         <= '0;
      block_o      <= '0;
    end else begin
      state_q <= state_d;
      start_o <= (state_q == ST_IDLE) && valid_i;
      if ((state_q == ST_IDLE) && valid_i) begin
        start_idx_o  <= idx_i;
        start_kind_o <= kind_i;
      end
      clear_o <= clr_d;
      tc_o    <= tc_d;
      block_o <= blk_d;
    end
  end
endmodule

// File: rtl/pdma_hs_irq.sv
module pdma_hs_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic irq_o
);
  logic st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= 1'b0;
    else if (set_i) st_q <= 1'b1;
    else if (clr_i) st_q <= 1'b0;
  end

  assign irq_o = st_q & en_i;
endmodule

// File: rtl/pdma_hs.sv
module pdma_hs
  import pdma_hs_pkg::*;
#(
  parameter int N   = 16,
  localparam int IDW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   burst_req_i,
  input  logic [N-1:0]   lburst_req_i,
  input  logic [N-1:0]   single_req_i,
  input  logic [N-1:0]   lsingle_req_i,
  input  logic           done_i,
  input  logic           cnt_zero_i,
  input  logic           err_i,
  input  logic           err_clr_i,
  input  logic           tc_clr_i,
  input  logic           err_en_i,
  input  logic           tc_en_i,
  output logic           start_o,
  output logic [IDW-1:0] start_periph_o,
  output logic           start_burst_o,
  output logic           start_last_o,
  output logic [N-1:0]   clear_o,
  output logic [N-1:0]   tc_o,
  output logic           irq_err_o,
  output logic           irq_tc_o,
  output logic           irq_o
);
  logic [N-1:0]   any, block;
  logic           valid;
  logic [IDW-1:0] idx;
  req_kind_t      kind, skind;
  logic [1:0]     set_v, clr_v, en_v, irq_v;

  pdma_hs_arb #(.N(N), .IDW(IDW)) u_arb (
    .burst_i  (burst_req_i),
    .lburst_i (lburst_req_i),
    .single_i (single_req_i),
    .lsingle_i(lsingle_req_i),
    .block_i  (block),
    .any_o    (any),
    .valid_o  (valid),
    .idx_o    (idx),
    .kind_o   (kind)
  );

  pdma_hs_ctrl #(.N(N), .IDW(IDW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid),
    .idx_i       (idx),
    .kind_i      (kind),
    .any_i       (any),
    .done_i      (done_i),
    .cnt_zero_i  (cnt_zero_i),
    .err_i       (err_i),
    .block_o     (block),
    .start_o     (start_o),
    .start_idx_o (start_periph_o),
    .start_kind_o(skind),
    .clear_o     (clear_o),
    .tc_o        (tc_o),
    .err_set_o   (set_v[0]),
    .tc_set_o    (set_v[1])
  );

  assign start_burst_o = skind.burst;
  assign start_last_o  = skind.last;

  assign clr_v = {tc_clr_i, err_clr_i};
  assign en_v  = {tc_en_i, err_en_i};

  // slot 0 error, slot 1 terminal count
  for (genvar g = 0; g < 2; g++) begin : g_irq
    pdma_hs_irq u_irq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .en_i  (en_v[g]),
      .irq_o (irq_v[g])
    );
  end

  assign irq_err_o = irq_v[0];
  assign irq_tc_o  = irq_v[1];
  assign irq_o     = |irq_v;
endmodule

// File: rtl/pdma_hs_chk.sv
module pdma_hs_chk #(
  parameter int N   = 16,
  parameter int IDW = $clog2(N)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           done_i,
  input logic           err_clr_i,
  input logic           err_en_i,
  input logic           start_o,
  input logic [IDW-1:0] start_periph_o,
  input logic [N-1:0]   clear_o,
  input logic [N-1:0]   tc_o,
  input logic           irq_err_o,
  input logic           irq_tc_o,
  input logic           irq_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               busy_q <= 1'b0;
    else if (start_o)          busy_q <= 1'b1;
    else if (busy_q && done_i) busy_q <= 1'b0;
  end

  a_r3_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_q);

  a_r4_clear_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clear_o));

  a_r4_clear_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o != '0) |=> (clear_o == '0));

  a_r11_clear_needs_busy_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o != '0) |-> $past(busy_q && done_i));

  a_r5_tc_with_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o & ~clear_o) == '0);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_err_o && !err_clr_i && err_en_i) |=> (irq_err_o || !err_en_i));

  a_r9_irq_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_err_o || irq_tc_o));
endmodule

bind pdma_hs pdma_hs_chk #(.N(N)) u_chk (.*);

// File: tb/pdma_hs_tb.sv
module pdma_hs_tb;
  localparam int N      = 16;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] breq = '0, lbreq = '0, sreq = '0, lsreq = '0;
  logic done = 0, cz = 0, err = 0, eclr = 0, tclr = 0, een = 1, ten = 1;
  logic start, sburst, slast, irq_err, irq_tc, irq;
  logic [3:0] sp;
  logic [N-1:0] clr, tc;
  int errors = 0, checks = 0;

  always #(CLK_NS / 2) clk = ~clk;

  pdma_hs #(.N(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .burst_req_i(breq), .lburst_req_i(lbreq), .single_req_i(sreq), .lsingle_req_i(lsreq),
    .done_i(done), .cnt_zero_i(cz), .err_i(err), .err_clr_i(eclr), .tc_clr_i(tclr),
    .err_en_i(een), .tc_en_i(ten),
    .start_o(start), .start_periph_o(sp), .start_burst_o(sburst), .start_last_o(slast),
    .clear_o(clr), .tc_o(tc), .irq_err_o(irq_err), .irq_tc_o(irq_tc), .irq_o(irq)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // start seen at this negedge; finish it and check clear / tc
  task automatic service(input int p, input bit b, input bit l, input bit z, input bit e,
                         input bit exp_tc, input string tag);
    chk(start == 1'b1, {tag, " R3 start"}, start, 1);
    chk(sp == 4'(p), {tag, " R1 periph"}, sp, p);
    chk(sburst == b, {tag, " R2 burst"}, sburst, b);
    chk(slast == l, {tag, " R2 last"}, slast, l);
    step();
    chk(start == 1'b0, {tag, " R3 one cycle"}, start, 0);
    chk(clr == '0, {tag, " R4 no early clear"}, clr, 0);
    done = 1; cz = z; err = e;
    step();
    done = 0; cz = 0; err = 0;
    chk(clr == N'(1) << p, {tag, " R4 clear"}, clr, N'(1) << p);
    chk(tc == (exp_tc ? N'(1) << p : '0), {tag, " R5 tc"}, tc, exp_tc ? N'(1) << p : 0);
  endtask

  task automatic t_reset();
    chk({start, sp, sburst, slast, clr, tc, irq_err, irq_tc, irq} == '0, "R10 reset", start, 0);
  endtask

  task automatic t_priority_hold();
    sreq[5] = 1; breq[3] = 1; sreq[3] = 1;
    step();
    service(3, 1, 0, 0, 0, 0, "prio");
    lsreq[9] = 1;
    step();
    service(5, 0, 0, 0, 0, 0, "R6 other");
    sreq[5] = 0;
    step();
    service(9, 0, 1, 0, 0, 1, "lsingle");
    lsreq[9] = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(start == 1'b0, "R6 held off", start, 0);
    end
    breq[3] = 0; sreq[3] = 0;
    step();
    breq[3] = 1;
    step();
    service(3, 1, 0, 0, 0, 0, "R6 reaccept");
    breq[3] = 0;
    step();
  endtask

  task automatic t_tc_irq();
    tclr = 1; step(); tclr = 0;
    chk(irq_tc == 1'b0, "R8 tc cleared", irq_tc, 0);
    lbreq[7] = 1; sreq[7] = 1;
    step();
    service(7, 1, 1, 0, 0, 1, "lburst");
    lbreq[7] = 0; sreq[7] = 0;
    chk(irq_tc == 1'b1 && irq == 1'b1, "R8 R9 tc irq", irq_tc, 1);
    ten = 0; #1;
    chk(irq_tc == 1'b0 && irq == 1'b0, "R9 tc masked", irq_tc, 0);
    ten = 1;
    step();
    chk(irq_tc == 1'b1, "R8 sticky", irq_tc, 1);
    tclr = 1; step(); tclr = 0;
    chk(irq_tc == 1'b0, "R8 w1c", irq_tc, 0);
    sreq[2] = 1;
    step();
    service(2, 0, 0, 1, 0, 1, "R5 cnt zero");
    sreq[2] = 0;
    chk(irq_tc == 1'b1, "R8 tc from counter", irq_tc, 1);
    tclr = 1; step(); tclr = 0;
  endtask

  task automatic t_error();
    breq[0] = 1;
    step();
    service(0, 1, 0, 0, 1, 0, "err");
    breq[0] = 0;
    chk(irq_err == 1'b1 && irq == 1'b1 && irq_tc == 1'b0, "R7 R9 err irq", irq_err, 1);
    een = 0; #1;
    chk(irq_err == 1'b0 && irq == 1'b0, "R9 err masked", irq_err, 0);
    een = 1;
    step(); step();
    chk(irq_err == 1'b1, "R7 sticky", irq_err, 1);
    eclr = 1; step(); eclr = 0;
    chk(irq_err == 1'b0, "R7 w1c", irq_err, 0);
    sreq[4] = 1;
    step();
    chk(start == 1'b1, "R3 start err2", start, 1);
    step();
    done = 1; err = 1; eclr = 1;
    step();
    done = 0; err = 0; eclr = 0; sreq[4] = 0;
    chk(irq_err == 1'b1, "R7 set wins", irq_err, 1);
    eclr = 1; step(); eclr = 0;
  endtask

  task automatic t_idle_done();
    step();
    done = 1; cz = 1; err = 1;
    step();
    done = 0; cz = 0; err = 0;
    chk(clr == '0 && tc == '0, "R11 no clear", clr, 0);
    chk(irq == 1'b0, "R11 no status", irq, 0);
    step();
    chk(irq == 1'b0 && start == 1'b0, "R11 still idle", irq, 0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_priority_hold();
    t_tc_irq();
    t_error();
    t_idle_done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule